// File: doc/BRIEF.md
# Ethernet MAC Management Register Bank with Duplex Monitor

This block is the software-visible control store of an Ethernet MAC. It keeps a word-addressed bank of 32-bit registers: two unicast station addresses, a 64-bit group-address hash table, and the general, receive and transmit control words. It presents each station address to the frame filter as one packed 48-bit value. It also presents the group table and the three control words as plain outputs.

One register drives the PHY management pins directly. Software toggles the clock bit and sets the data and output-enable bits one write at a time. The current level of the shared data line can be read back from the status word. The slave sees a clock half-cycle only when a write actually changes the clock bit.

The block also watches for a duplex disagreement between the MAC and the PHY. The MAC setting is bit 7 of receive control. The PHY setting is bit 11 of a diagnostics word supplied on an input port. The comparison runs again on every receive-control write and on every management write that flips the clock bit. The comparison has effect only while the enable bit of general control is set. A one-cycle pulse marks every change of the stored mismatch flag.

Top module: `eth_mgmt_regs`

## Requirements
- R1: After reset, every register, both station addresses, the group table, the control outputs, the management pins, the mismatch flag and the change pulse are all zero.
- R2: A write to word offset 0 to 22 is stored and read back unchanged on `rd_data` in the same cycle that `req_addr` selects it. Offset 11 is the exception. Reads of offsets 23 to 31 return zero, and writes to them change nothing.
- R3: Station address 0 equals {offset 1 bits 15..0, offset 0}, so that address byte 0 sits in bits 7..0. Station address 1 is packed the same way from offsets 3 and 2.
- R4: The group table is {offset 5, offset 4}. The general, receive and transmit control outputs show offsets 6, 7 and 8.
- R5: The management word is offset 10. `mdc` follows its bit 2, `mdio_oe` follows bit 1 and `mdio_o` follows bit 0, starting the cycle after the write.
- R6: A read of offset 11 returns zero in bits 31..1. Bit 0 holds the line level, which is `mdio_o` when `mdio_oe` is 1 and `mdio_i` otherwise.
- R7: If general-control bit 0 is set, a receive-control write sets the mismatch flag in the next cycle. The flag is set to the written bit 7 XOR `phy_diag` bit 11.
- R8: A management write re-evaluates the flag only if its bit 2 differs from the current `mdc`. In that case the flag becomes the stored receive-control bit 7 XOR `phy_diag` bit 11. A management write that leaves bit 2 unchanged leaves the flag as it was.
- R9: While general-control bit 0 is clear, the mismatch flag holds its value whatever is written.
- R10: `mismatch_change` is high for exactly the one cycle in which `duplex_mismatch` first shows a new value. It is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_write | input | 1 | Write strobe for the addressed word |
| req_addr | input | 5 | Word offset for reads and writes |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `req_addr` (combinational) |
| mdio_i | input | 1 | Sensed level of the management data line |
| mdc | output | 1 | Management clock |
| mdio_oe | output | 1 | Management data output enable |
| mdio_o | output | 1 | Management data output value |
| phy_diag | input | 16 | PHY diagnostics word; bit 11 is the PHY duplex |
| station_addr0 | output | 48 | Packed station address 0 |
| station_addr1 | output | 48 | Packed station address 1 |
| group_table | output | 64 | Group-address hash table |
| gen_ctrl | output | 32 | General control word |
| rx_ctrl | output | 32 | Receive control word |
| tx_ctrl | output | 32 | Transmit control word |
| duplex_mismatch | output | 1 | Stored duplex mismatch flag |
| mismatch_change | output | 1 | One-cycle pulse on a flag change |

## Verification
The hardest state to reach is a stale mismatch flag. This is a flag whose stored value no longer matches the current MAC and PHY settings. It is stale because no trigger has re-evaluated it yet. The stimulus first sets the flag through a receive-control write. It then flips the PHY duplex bit on its input without any trigger. A management write with an unchanged clock bit follows, and it must leave the flag alone. Only a later clock-flipping write may clear the flag and pulse the change output. The same triggers are then repeated with the enable bit cleared, to show that the flag holds.

// File: rtl/eth_mgmt_pkg.sv
package eth_mgmt_pkg;
    // Word offsets whose meaning other logic depends on
    localparam int unsigned OFS_STA0_LO  = 0;
    localparam int unsigned OFS_STA0_HI  = 1;
    localparam int unsigned OFS_GRP_LO   = 4;
    localparam int unsigned OFS_GRP_HI   = 5;
    localparam int unsigned OFS_GEN      = 6;
    localparam int unsigned OFS_RX       = 7;
    localparam int unsigned OFS_TX       = 8;
    localparam int unsigned OFS_MGMT     = 10;
    localparam int unsigned OFS_STATUS   = 11;

    // Management word bit positions
    localparam int unsigned MGMT_DOUT_BIT = 0;
    localparam int unsigned MGMT_OE_BIT   = 1;
    localparam int unsigned MGMT_CLK_BIT  = 2;

    // General-control enable bit for duplex monitoring
    localparam int unsigned GEN_EN_BIT    = 0;

    typedef struct packed {
        logic flag;
        logic change;
    } dup_state_t;
endpackage

// File: rtl/eth_mgmt_regbank.sv
module eth_mgmt_regbank
    import eth_mgmt_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned NUM_WORDS = 23
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    input  logic                             line_level,
    output logic [DATA_W-1:0]                rd_data,
    output logic [NUM_WORDS-1:0][DATA_W-1:0] words_o
);
    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] words;
    } bank_t;

    bank_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (wr_en && (addr == ADDR_W'(i))) begin
                s_d.words[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // Read mux: status word reports the live line level
    always_comb begin
        rd_data = '0;
        if (addr == ADDR_W'(OFS_STATUS)) begin
            rd_data[0] = line_level;
        end else begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (addr == ADDR_W'(i)) begin
                    rd_data = s_q.words[i];
                end
            end
        end
    end

    assign words_o = s_q.words;
endmodule

// File: rtl/eth_mgmt_duplex.sv
module eth_mgmt_duplex
    import eth_mgmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic eval,
    input  logic enable,
    input  logic mac_duplex,
    input  logic phy_duplex,
    output logic mismatch,
    output logic change
);
    dup_state_t s_d, s_q;
    logic       differ;

    always_comb begin
        s_d        = s_q;
        s_d.change = 1'b0;
        differ     = mac_duplex ^ phy_duplex;
        if (eval && enable && (differ != s_q.flag)) begin
            s_d.flag   = differ;
            s_d.change = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mismatch = s_q.flag;
    assign change   = s_q.change;
endmodule

// File: rtl/eth_mgmt_regs.sv
module eth_mgmt_regs
    import eth_mgmt_pkg::*;
#(
    parameter int unsigned DATA_W         = 32,
    parameter int unsigned ADDR_W         = 5,
    parameter int unsigned NUM_WORDS      = 23,
    parameter int unsigned PHY_W          = 16,
    parameter int unsigned PHY_DUPLEX_BIT = 11,
    parameter int unsigned MAC_DUPLEX_BIT = 7,
    parameter int unsigned STA_W          = 48
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic [DATA_W-1:0]   rd_data,
    input  logic                mdio_i,
    output logic                mdc,
    output logic                mdio_oe,
    output logic                mdio_o,
    input  logic [PHY_W-1:0]    phy_diag,
    output logic [STA_W-1:0]    station_addr0,
    output logic [STA_W-1:0]    station_addr1,
    output logic [2*DATA_W-1:0] group_table,
    output logic [DATA_W-1:0]   gen_ctrl,
    output logic [DATA_W-1:0]   rx_ctrl,
    output logic [DATA_W-1:0]   tx_ctrl,
    output logic                duplex_mismatch,
    output logic                mismatch_change
);
    localparam int unsigned NUM_STA = 2;
    localparam int unsigned HI_W    = STA_W - DATA_W;

    logic [NUM_WORDS-1:0][DATA_W-1:0] words;
    logic [NUM_STA-1:0][STA_W-1:0]    sta;
    logic [DATA_W-1:0]                mgmt_w;
    logic                             line_level;
    logic                             wr_rx, wr_mgmt, clk_flip, eval;
    logic                             mac_dup;
    logic                             unused_ok;

    eth_mgmt_regbank #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)
    ) bank_i (
        .clk(clk), .rst_n(rst_n), .wr_en(req_write), .addr(req_addr),
        .wdata(req_wdata), .line_level(line_level),
        .rd_data(rd_data), .words_o(words)
    );

    // Station address packing, byte 0 in the low bits
    for (genvar g = 0; g < NUM_STA; g++) begin : g_sta
        assign sta[g] = {words[OFS_STA0_HI + 2*g][HI_W-1:0],
                         words[OFS_STA0_LO + 2*g]};
    end
    assign station_addr0 = sta[0];
    assign station_addr1 = sta[1];

    assign group_table = {words[OFS_GRP_HI], words[OFS_GRP_LO]};
    assign gen_ctrl    = words[OFS_GEN];
    assign rx_ctrl     = words[OFS_RX];
    assign tx_ctrl     = words[OFS_TX];

    // Management pins straight from the management word
    assign mgmt_w     = words[OFS_MGMT];
    assign mdc        = mgmt_w[MGMT_CLK_BIT];
    assign mdio_oe    = mgmt_w[MGMT_OE_BIT];
    assign mdio_o     = mgmt_w[MGMT_DOUT_BIT];
    assign line_level = mdio_oe ? mdio_o : mdio_i;

    // Duplex re-evaluation triggers
    assign wr_rx    = req_write && (req_addr == ADDR_W'(OFS_RX));
    assign wr_mgmt  = req_write && (req_addr == ADDR_W'(OFS_MGMT));
    assign clk_flip = wr_mgmt && (req_wdata[MGMT_CLK_BIT] != mdc);
    assign eval     = wr_rx || clk_flip;
    assign mac_dup  = wr_rx ? req_wdata[MAC_DUPLEX_BIT]
                            : words[OFS_RX][MAC_DUPLEX_BIT];

    eth_mgmt_duplex dup_i (
        .clk(clk), .rst_n(rst_n), .eval(eval),
        .enable(words[OFS_GEN][GEN_EN_BIT]),
        .mac_duplex(mac_dup), .phy_duplex(phy_diag[PHY_DUPLEX_BIT]),
        .mismatch(duplex_mismatch), .change(mismatch_change)
    );

    assign unused_ok = ^{words, phy_diag};
endmodule

// File: rtl/eth_mgmt_chk.sv
module eth_mgmt_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    parameter int unsigned STA_W  = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] req_wdata,
    input logic [DATA_W-1:0] rd_data,
    input logic              mdio_i,
    input logic              mdio_oe,
    input logic [STA_W-1:0]  station_addr0,
    input logic [DATA_W-1:0] gen_ctrl,
    input logic [DATA_W-1:0] rx_ctrl,
    input logic              duplex_mismatch,
    input logic              mismatch_change
);
    // R10
    pulse_has_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_change |-> (duplex_mismatch != $past(duplex_mismatch)));

    // R10
    change_has_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (duplex_mismatch != $past(duplex_mismatch)) |-> mismatch_change);

    // R9
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(gen_ctrl[0]) |-> $stable(duplex_mismatch));

    // R7
    rx_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_write && req_addr == ADDR_W'(7)) |-> rx_ctrl == $past(req_wdata));

    // R6
    status_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr == ADDR_W'(11) && !mdio_oe) |-> rd_data == {{(DATA_W-1){1'b0}}, mdio_i});

    // R3
    sta_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && req_write && req_addr == ADDR_W'(0)) |-> station_addr0[DATA_W-1:0] == $past(req_wdata));
endmodule

bind eth_mgmt_regs eth_mgmt_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STA_W(STA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_data(rd_data), .mdio_i(mdio_i), .mdio_oe(mdio_oe),
    .station_addr0(station_addr0), .gen_ctrl(gen_ctrl), .rx_ctrl(rx_ctrl),
    .duplex_mismatch(duplex_mismatch), .mismatch_change(mismatch_change)
);

// File: tb/eth_mgmt_regs_tb_top.sv
`timescale 1ns/1ps
module eth_mgmt_regs_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        mdio_i = 1'b0;
    logic        mdc, mdio_oe, mdio_o;
    logic [15:0] phy_diag = '0;
    logic [47:0] station_addr0, station_addr1;
    logic [63:0] group_table;
    logic [31:0] gen_ctrl, rx_ctrl, tx_ctrl;
    logic        duplex_mismatch, mismatch_change;

    always #10 clk = ~clk;

    eth_mgmt_regs dut_i (
        .clk(clk), .rst_n(rst_n), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .mdio_i(mdio_i), .mdc(mdc),
        .mdio_oe(mdio_oe), .mdio_o(mdio_o), .phy_diag(phy_diag),
        .station_addr0(station_addr0), .station_addr1(station_addr1),
        .group_table(group_table), .gen_ctrl(gen_ctrl), .rx_ctrl(rx_ctrl),
        .tx_ctrl(tx_ctrl), .duplex_mismatch(duplex_mismatch),
        .mismatch_change(mismatch_change)
    );

    typedef struct {
        string       tag;
        int          sel;
        logic [63:0] exp;
    } item_t;

    item_t q[$];
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    localparam int S_RD = 0, S_STA0 = 1, S_STA1 = 2, S_GRP = 3, S_PINS = 4,
                   S_FLAG = 5, S_CHG = 6, S_GEN = 7, S_RX = 8, S_TX = 9;

    function automatic logic [63:0] observe(int sel);
        case (sel)
            S_RD:    return {32'b0, rd_data};
            S_STA0:  return {16'b0, station_addr0};
            S_STA1:  return {16'b0, station_addr1};
            S_GRP:   return group_table;
            S_PINS:  return {61'b0, mdc, mdio_oe, mdio_o};
            S_FLAG:  return {63'b0, duplex_mismatch};
            S_CHG:   return {63'b0, mismatch_change};
            S_GEN:   return {32'b0, gen_ctrl};
            S_RX:    return {32'b0, rx_ctrl};
            default: return {32'b0, tx_ctrl};
        endcase
    endfunction

    // Monitor: compare every queued expectation at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [63:0] got;
            it  = q.pop_front();
            got = observe(it.sel);
            n_chk++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    function automatic logic [31:0] pat(int i);
        return {8'hC3, 8'(i), 8'(i * 3), 8'(i * 2)};
    endfunction

    task automatic expect_val(string tag, int sel, logic [63:0] exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic rd_chk(string tag, logic [4:0] a, logic [31:0] exp);
        req_addr = a;
        expect_val(tag, S_RD, {32'b0, exp});
    endtask

    task automatic do_write(logic [4:0] a, logic [31:0] d);
        @(posedge clk);
        #1;
        req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        #1;
        req_write = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        expect_val("R1 sta0", S_STA0, 64'h0);
        expect_val("R1 grp", S_GRP, 64'h0);
        expect_val("R1 pins", S_PINS, 64'h0);
        expect_val("R1 flag", S_FLAG, 64'h0);
        expect_val("R1 change", S_CHG, 64'h0);
        expect_val("R1 rx", S_RX, 64'h0);
        rd_chk("R1 rd tx", 5'd8, 32'h0);

        // R2 fill every implemented word, evaluation disabled (gen bit0 = 0)
        for (int i = 0; i < 23; i++) do_write(5'(i), pat(i));
        for (int i = 0; i < 23; i++) begin
            if (i != 11) rd_chk("R2 readback", 5'(i), pat(i));
        end
        do_write(5'd23, 32'hFFFF_FFFF);
        do_write(5'd31, 32'h1234_5678);
        rd_chk("R2 off23", 5'd23, 32'h0);
        rd_chk("R2 off31", 5'd31, 32'h0);
        rd_chk("R2 off22 kept", 5'd22, pat(22));

        // R3 / R4 packed outputs
        expect_val("R3 sta0", S_STA0, {16'b0, pat(1)[15:0], pat(0)});
        expect_val("R3 sta1", S_STA1, {16'b0, pat(3)[15:0], pat(2)});
        expect_val("R4 grp", S_GRP, {pat(5), pat(4)});
        expect_val("R4 gen", S_GEN, {32'b0, pat(6)});
        expect_val("R4 rx", S_RX, {32'b0, pat(7)});
        expect_val("R4 tx", S_TX, {32'b0, pat(8)});
        expect_val("R9 flag held", S_FLAG, 64'h0);

        // R5 / R6 management pins and line level
        expect_val("R5 pins pattern", S_PINS, 64'h4);
        mdio_i = 1'b0;
        rd_chk("R6 status in0", 5'd11, 32'h0);
        mdio_i = 1'b1;
        rd_chk("R6 status in1", 5'd11, 32'h1);
        do_write(5'd10, 32'h7);
        expect_val("R5 pins 111", S_PINS, 64'h7);
        mdio_i = 1'b0;
        rd_chk("R6 status drive1", 5'd11, 32'h1);
        do_write(5'd10, 32'h2);
        expect_val("R5 pins 010", S_PINS, 64'h2);
        mdio_i = 1'b1;
        rd_chk("R6 status drive0", 5'd11, 32'h0);
        do_write(5'd10, 32'h0);
        rd_chk("R6 status release", 5'd11, 32'h1);
        mdio_i = 1'b0;

        // Duplex monitoring
        phy_diag = 16'h0800;
        do_write(5'd6, 32'h0);
        do_write(5'd7, 32'h00);
        expect_val("R9 disabled rx write", S_FLAG, 64'h0);
        expect_val("R9 no pulse", S_CHG, 64'h0);
        do_write(5'd6, 32'h1);
        do_write(5'd7, 32'h80);
        expect_val("R7 agree", S_FLAG, 64'h0);
        expect_val("R10 no pulse agree", S_CHG, 64'h0);
        do_write(5'd7, 32'h00);
        expect_val("R10 pulse high", S_CHG, 64'h1);
        expect_val("R10 pulse low", S_CHG, 64'h0);
        expect_val("R7 mismatch", S_FLAG, 64'h1);
        do_write(5'd7, 32'h00);
        expect_val("R10 no repeat pulse", S_CHG, 64'h0);
        phy_diag = 16'h0000;
        expect_val("R8 stale flag", S_FLAG, 64'h1);
        do_write(5'd10, 32'h1);
        expect_val("R8 same clk no eval", S_FLAG, 64'h1);
        expect_val("R8 same clk no pulse", S_CHG, 64'h0);
        do_write(5'd10, 32'h4);
        expect_val("R8 clk flip pulse", S_CHG, 64'h1);
        expect_val("R8 clk flip clears", S_FLAG, 64'h0);
        do_write(5'd6, 32'h0);
        phy_diag = 16'h0800;
        do_write(5'd10, 32'h0);
        expect_val("R9 flip while off", S_FLAG, 64'h0);
        do_write(5'd6, 32'h1);
        do_write(5'd10, 32'h4);
        expect_val("R8 flip sets", S_FLAG, 64'h1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #3_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule